// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches the low sixteen lines of a digital input bus and raises an interrupt request when a programmed change-of-state condition holds. Two masks pick, for each channel, what it responds to. A control register turns the block on and selects one of two ways to combine the channels. In the edge mode, a selected edge on any enabled channel fires. In the level mode, every enabled channel must be at its chosen level at the same time.

Software first writes both masks and then sets the enable bit. When the request is raised, software reads the status register. The read tells which channels were responsible and also clears the latched result. In the level mode the logic then stays blocked until one of the selected inputs changes level. This stops a condition that simply persists from firing again and again.

Top module: `cos_irq_ctrl`

Register map (`addr`): 0 = high mask (rising edge / high level), 1 = low mask (falling edge / low level), 2 = control (bit 0 enable, bit 1 combine mode: 0 = edge/any, 1 = level/all), 3 = status (a read clears it). All registers read back on `rdata`. A write takes effect at the rising clock edge on which `wr_en` is high.

## Requirements
- R1: Only `din[15:0]` take part. Edges or levels on `din` bits 16 and above never set status or raise `irq`.
- R2: In edge mode (control = 1), a rising edge on a channel whose high-mask bit is set sets that status bit. `irq` is high once the third rising clock edge after the input change has passed.
- R3: In edge mode, a falling edge on a channel whose low-mask bit is set sets that status bit, with the same latency as R2.
- R4: In edge mode, an edge that is not selected has no effect. This covers the opposite edge, an unmasked channel, and any edge when both masks are zero.
- R5: In edge mode, a channel set in both masks responds to both its rising and its falling edge.
- R6: In level mode (control = 3), `irq` rises only when every channel set in exactly one mask is at its level: high for the high mask, low for the low mask. The status then holds the set of those channels.
- R7: In level mode, a channel set in both masks is left out of the condition and out of the status. With no channel selected, the block never fires.
- R8: In level mode, after a firing the logic is blocked until a selected channel changes level. Changes on unselected or excluded channels do not release it.
- R9: Control bit 0 enables the block and bit 1 selects the level mode. Enabling the level mode while the condition already holds fires once. Control reads back the written bits.
- R10: Writing an enable of 0 to control clears the status, and `irq` is low after that clock edge. Edges that occur while the block is disabled are not recorded.
- R11: A read of status returns the latched bits and clears them, so `irq` drops. Events that arrive while a request is pending OR into the status.
- R12: After reset, `irq` is low and the masks, control and status all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | IN_W (32) | Asynchronous digital input bus |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status at addr 3) |
| addr | input | 2 | Register address |
| wdata | input | CH_N (16) | Write data |
| rdata | output | CH_N (16) | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request, high while status is non-zero |

## Verification
The hardest case to reach is the blocked state of the level mode. Here the condition still holds after a firing, so the only sign of correct behaviour is that nothing happens. The stimulus gets there by satisfying the condition, reading status, and then holding the inputs. Next it toggles an unselected channel and a channel that is set in both masks, checking that `irq` stays low. Only after that does it drop and restore a selected channel to show that the logic is released. A second hard case is enabling the block while the condition already holds. It is reached by disabling and re-enabling the level mode with the inputs unchanged.

// File: rtl/cos_pkg.sv
// Shared definitions for the change-of-state interrupt controller.
// Assumes a 2-bit register address space.
package cos_pkg;
    typedef enum logic [1:0] {
        A_HIMASK = 2'd0,
        A_LOMASK = 2'd1,
        A_CTRL   = 2'd2,
        A_STAT   = 2'd3
    } reg_addr_e;

    typedef enum logic {
        M_ANY = 1'b0,
        M_ALL = 1'b1
    } cmb_mode_e;

    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MODE_BIT = 1;
endpackage

// File: rtl/cos_sync.sv
// Two-flop synchronizer followed by a history flop.
// Provides the current settled sample and the sample one cycle older,
// so that the evaluator can see edges. Assumes din is asynchronous.
module cos_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    // Synchronizer chain plus one stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= din;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/cos_eval.sv
// Change-of-state evaluator. Combines the two masks with the sampled
// inputs according to the mode and reports, each cycle, the channels that
// fire. The level mode keeps an arm flag that is cleared by a firing and
// set again by a level change on a selected channel. Assumes cur and prev
// come from cos_sync.
module cos_eval
    import cos_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  cmb_mode_e    mode,
    input  logic [W-1:0] m_hi,
    input  logic [W-1:0] m_lo,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    output logic [W-1:0] hits,
    output logic         chg
);
    logic [W-1:0] rise, fall, want_hi, want_lo, sel;
    logic         cond, and_fire, armed;

    // Edge terms, level selection and the hit vector for this cycle.
    always_comb begin
        rise     = cur & ~prev;
        fall     = ~cur & prev;
        want_hi  = m_hi & ~m_lo;
        want_lo  = m_lo & ~m_hi;
        sel      = want_hi | want_lo;
        cond     = (sel != '0) && ((cur & want_hi) == want_hi)
                   && ((~cur & want_lo) == want_lo);
        chg      = |((cur ^ prev) & sel);
        and_fire = en && (mode == M_ALL) && cond && (armed || chg);
        if (en && (mode == M_ANY))
            hits = (rise & m_hi) | (fall & m_lo);
        else if (and_fire)
            hits = sel;
        else
            hits = '0;
    end

    // Re-arm flag for the level mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            armed <= 1'b1;
        else if (and_fire)
            armed <= 1'b0;
        else if (chg)
            armed <= 1'b1;
    end
endmodule

// File: rtl/cos_irq_ctrl.sv
// Change-of-state interrupt controller, top level.
// Holds the mask, control and status registers and drives irq from the
// latched status. Only the low CH_N input lines are watched. Assumes a
// single-cycle register strobe and IN_W > CH_N.
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int unsigned IN_W = 32,
    parameter int unsigned CH_N = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] din,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [CH_N-1:0] wdata,
    output logic [CH_N-1:0] rdata,
    output logic            irq
);
    logic [CH_N-1:0] m_hi, m_lo, status_q, hits, cur, prev;
    logic            ctrl_en, en_next, chg;
    cmb_mode_e       ctrl_mode;
    reg_addr_e       ra;
    logic            unused_hi;

    assign ra        = reg_addr_e'(addr);
    assign unused_hi = ^din[IN_W-1:CH_N];

    cos_sync #(.W(CH_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(din[CH_N-1:0]),
        .cur(cur), .prev(prev)
    );

    cos_eval #(.W(CH_N)) u_eval (
        .clk(clk), .rst_n(rst_n), .en(ctrl_en), .mode(ctrl_mode),
        .m_hi(m_hi), .m_lo(m_lo), .cur(cur), .prev(prev),
        .hits(hits), .chg(chg)
    );

    // Enable value that will hold after this edge.
    always_comb begin
        en_next = ctrl_en;
        if (wr_en && ra == A_CTRL)
            en_next = wdata[CTRL_EN_BIT];
    end

    // Mask and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_hi      <= '0;
            m_lo      <= '0;
            ctrl_en   <= 1'b0;
            ctrl_mode <= M_ANY;
        end else if (wr_en) begin
            case (ra)
                A_HIMASK: m_hi <= wdata;
                A_LOMASK: m_lo <= wdata;
                A_CTRL: begin
                    ctrl_en   <= wdata[CTRL_EN_BIT];
                    ctrl_mode <= cmb_mode_e'(wdata[CTRL_MODE_BIT]);
                end
                default: ;
            endcase
        end
    end

    // Status latch: accumulate hits, clear on read or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_next)
            status_q <= '0;
        else if (rd_en && ra == A_STAT)
            status_q <= hits;
        else
            status_q <= status_q | hits;
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (ra)
            A_HIMASK: rdata = m_hi;
            A_LOMASK: rdata = m_lo;
            A_CTRL: begin
                rdata[CTRL_EN_BIT]   = ctrl_en;
                rdata[CTRL_MODE_BIT] = ctrl_mode;
            end
            A_STAT:   rdata = status_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = |status_q;
endmodule

// File: rtl/cos_irq_ctrl_checker.sv
// Assertion checker for cos_irq_ctrl, attached by bind.
module cos_irq_ctrl_checker #(
    parameter int unsigned CH_N = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic [1:0]      addr,
    input logic            en,
    input logic            mode,
    input logic [CH_N-1:0] m_hi,
    input logic [CH_N-1:0] m_lo,
    input logic [CH_N-1:0] hits,
    input logic            chg,
    input logic            irq
);
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd3 && hits == '0 && !wr_en) |=> !irq);

    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && addr == 2'd3) && !wr_en) |=> irq);

    a_r2_edge_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !mode && hits != '0 && !wr_en) |=> irq);

    a_r8_and_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode && hits != '0 && !wr_en) |=> (hits == '0 || chg));

    a_r7_both_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode && hits != '0) |-> ((hits & m_hi & m_lo) == '0));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_checker #(.CH_N(CH_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .en(ctrl_en), .mode(ctrl_mode), .m_hi(m_hi), .m_lo(m_lo),
    .hits(hits), .chg(chg), .irq(irq)
);

// File: tb/cos_irq_ctrl_bench.sv
module cos_irq_ctrl_bench;
    localparam int IN_W = 32;
    localparam int CH_N = 16;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_DRV = 2'd2;
    localparam int NV = 57;
    // {op[55:54], addr[53:52], data[51:20], expect[19:4], req[3:0]}
    // RD: expect = rdata; WR/DRV: expect[0] = irq after the step.
    localparam logic [55:0] TBL [0:NV-1] = '{
        {OP_RD,  2'd0, 32'h0, 16'h0000, 4'd12},  // R12 masks, ctrl, status
        {OP_RD,  2'd1, 32'h0, 16'h0000, 4'd12},
        {OP_RD,  2'd2, 32'h0, 16'h0000, 4'd12},
        {OP_RD,  2'd3, 32'h0, 16'h0000, 4'd12},
        {OP_WR,  2'd0, 32'h0001, 16'h0, 4'd9},
        {OP_WR,  2'd1, 32'h0002, 16'h0, 4'd9},
        {OP_WR,  2'd2, 32'h0001, 16'h0, 4'd9},   // R9 edge mode on
        {OP_RD,  2'd2, 32'h0, 16'h0001, 4'd9},
        {OP_DRV, 2'd0, 32'h00000002, 16'h0, 4'd4},  // R4 wrong edge
        {OP_DRV, 2'd0, 32'h00000003, 16'h1, 4'd2},  // R2 ch0 rise
        {OP_RD,  2'd3, 32'h0, 16'h0001, 4'd2},
        {OP_DRV, 2'd0, 32'h00000003, 16'h0, 4'd11}, // R11 read cleared
        {OP_DRV, 2'd0, 32'h00000001, 16'h1, 4'd3},  // R3 ch1 fall
        {OP_RD,  2'd3, 32'h0, 16'h0002, 4'd3},
        {OP_DRV, 2'd0, 32'hFFFF0001, 16'h0, 4'd1},  // R1 upper rise
        {OP_DRV, 2'd0, 32'h00000001, 16'h0, 4'd1},  // R1 upper fall
        {OP_DRV, 2'd0, 32'h00000000, 16'h0, 4'd4},
        {OP_DRV, 2'd0, 32'h00000001, 16'h1, 4'd2},
        {OP_DRV, 2'd0, 32'h00000002, 16'h1, 4'd11}, // R11 pending holds
        {OP_DRV, 2'd0, 32'h00000000, 16'h1, 4'd11},
        {OP_RD,  2'd3, 32'h0, 16'h0003, 4'd11},     // R11 ORed bits
        {OP_DRV, 2'd0, 32'h00000010, 16'h0, 4'd4},  // R4 unmasked ch4
        {OP_WR,  2'd0, 32'h0005, 16'h0, 4'd5},
        {OP_WR,  2'd1, 32'h0006, 16'h0, 4'd5},
        {OP_DRV, 2'd0, 32'h00000014, 16'h1, 4'd5},  // R5 ch2 rise
        {OP_RD,  2'd3, 32'h0, 16'h0004, 4'd5},
        {OP_DRV, 2'd0, 32'h00000010, 16'h1, 4'd5},  // R5 ch2 fall
        {OP_RD,  2'd3, 32'h0, 16'h0004, 4'd5},
        {OP_DRV, 2'd0, 32'h00000011, 16'h1, 4'd2},
        {OP_WR,  2'd2, 32'h0000, 16'h0, 4'd10},     // R10 disable
        {OP_RD,  2'd3, 32'h0, 16'h0000, 4'd10},
        {OP_DRV, 2'd0, 32'h00000015, 16'h0, 4'd10},
        {OP_WR,  2'd0, 32'h00B0, 16'h0, 4'd6},
        {OP_WR,  2'd1, 32'h00C0, 16'h0, 4'd6},
        {OP_WR,  2'd2, 32'h0003, 16'h0, 4'd9},      // R9 level mode
        {OP_DRV, 2'd0, 32'h00000010, 16'h0, 4'd6},  // R6 ch5 low
        {OP_DRV, 2'd0, 32'h00000070, 16'h0, 4'd6},  // R6 ch6 high
        {OP_DRV, 2'd0, 32'h00000030, 16'h1, 4'd6},  // R6 all met
        {OP_RD,  2'd3, 32'h0, 16'h0070, 4'd7},      // R7 ch7 excluded
        {OP_DRV, 2'd0, 32'h00000030, 16'h0, 4'd8},  // R8 blocked
        {OP_DRV, 2'd0, 32'h00000034, 16'h0, 4'd8},
        {OP_DRV, 2'd0, 32'h000000B4, 16'h0, 4'd8},
        {OP_DRV, 2'd0, 32'h000000A4, 16'h0, 4'd8},
        {OP_DRV, 2'd0, 32'h000000B4, 16'h1, 4'd8},  // R8 released
        {OP_RD,  2'd3, 32'h0, 16'h0070, 4'd6},
        {OP_WR,  2'd2, 32'h0000, 16'h0, 4'd10},
        {OP_WR,  2'd2, 32'h0003, 16'h0, 4'd9},
        {OP_DRV, 2'd0, 32'h000000B4, 16'h1, 4'd9},  // R9 fire on enable
        {OP_RD,  2'd3, 32'h0, 16'h0070, 4'd9},
        {OP_WR,  2'd2, 32'h0000, 16'h0, 4'd10},
        {OP_WR,  2'd0, 32'h0000, 16'h0, 4'd7},
        {OP_WR,  2'd1, 32'h0000, 16'h0, 4'd7},
        {OP_WR,  2'd2, 32'h0003, 16'h0, 4'd7},
        {OP_DRV, 2'd0, 32'h000000B4, 16'h0, 4'd7},  // R7 empty selection
        {OP_WR,  2'd2, 32'h0001, 16'h0, 4'd4},
        {OP_DRV, 2'd0, 32'h0000FFFF, 16'h0, 4'd4},  // R4 zero masks
        {OP_DRV, 2'd0, 32'h00000000, 16'h0, 4'd4}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IN_W-1:0] din = '0;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]      addr = '0;
    logic [CH_N-1:0] wdata = '0;
    logic [CH_N-1:0] rdata;
    logic            irq;
    int              checks = 0, errors = 0;
    logic            done = 1'b0;

    always #10 clk = ~clk;

    cos_irq_ctrl #(.IN_W(IN_W), .CH_N(CH_N)) u_cos_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input int req, input logic [CH_N-1:0] act,
                         input logic [CH_N-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [CH_N-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [CH_N-1:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_drive(input logic [IN_W-1:0] d);
        @(negedge clk); din = d;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [CH_N-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(12, {15'd0, irq}, 16'h0, "irq after reset");   // R12
        for (int i = 0; i < NV; i++) begin
            logic [55:0] e;
            e = TBL[i];
            case (e[55:54])
                OP_RD: begin
                    do_read(e[53:52], v);
                    check(int'(e[3:0]), v, e[19:4], "register read");
                end
                OP_WR: begin
                    do_write(e[53:52], e[35:20]);
                    check(int'(e[3:0]), {15'd0, irq}, e[19:4], "irq after write");
                end
                default: begin
                    do_drive(e[51:20]);
                    check(int'(e[3:0]), {15'd0, irq}, e[19:4], "irq after input");
                end
            endcase
        end
        // R12: reset while a request is pending clears everything.
        do_write(2'd0, 16'h0001);
        do_write(2'd2, 16'h0001);
        do_drive(32'h1);
        check(2, {15'd0, irq}, 16'h1, "R2 irq before reset");
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(12, {15'd0, irq}, 16'h0, "R12 irq in reset");
        rst_n = 1'b1;
        do_read(2'd0, v);
        check(12, v, 16'h0, "R12 mask after reset");
        do_read(2'd2, v);
        check(12, v, 16'h0, "R12 ctrl after reset");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule